// File: doc/BRIEF.md
# Legacy Video Memory Window Decoder

This block sits between a host bus and a linear video memory. Host accesses aimed at the legacy 128 KB display aperture (physical 0xA0000 to 0xBFFFF) are translated into a byte address inside the video memory. The translation depends on a two-bit map selection taken from graphics register 6. One of the map settings moves a 64 KB window to a programmable bank base supplied by the mode register logic. Accesses that fall outside the selected window never reach memory. Reads of such addresses return all ones, and writes to them are discarded.

The host may write one, two or four bytes at a time. Wide writes are broken into byte writes on consecutive cycles, lowest byte and lowest address first. Each byte is decoded on its own, so a wide write that straddles a window edge lands only partly. Every byte that reaches memory marks its page in a dirty bitmap, which a display engine reads and clears by page range.

Top module: `legacy_window_decoder`

## Requirements
- R1: The map selection is bits 3:2 of `gr6`; the other bits have no effect. Selection 0 accepts 0xA0000 to 0xBFFFF and maps each address to (address - 0xA0000).
- R2: Selection 1 accepts 0xA0000 to 0xAFFFF and maps it to `bank_base` + (address - 0xA0000), wrapping modulo the video memory size; 0xB0000 and above are rejected.
- R3: Selection 2 accepts 0xB0000 to 0xB7FFF and maps it to (address - 0xB0000); everything else is rejected.
- R4: Selection 3 accepts 0xB8000 to 0xBFFFF and maps it to (address - 0xB8000); everything else is rejected.
- R5: A byte address below 0xA0000 or above 0xBFFFF is rejected under every selection, and `win_hit` / `win_miss` report acceptance of the byte currently presented.
- R6: A read is always one byte. An accepted read strobes memory and returns `mem_rdata` on `req_rdata`; a rejected read returns 0xFF with no memory strobe.
- R7: A rejected write byte produces no memory strobe and leaves the dirty bitmap unchanged.
- R8: `req_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. Byte k of a write is presented in the k-th cycle of the request at address `req_addr` + k with data `req_wdata[8k+7:8k]`.
- R9: `req_ready` is high in the cycle of the last byte of a request (the first cycle for reads and single-byte writes); the host holds the request until then.
- R10: Each accepted write byte sets dirty bit (memory address >> PAGE_SHIFT), visible from the next cycle; with no write and no clear the bitmap holds.
- R11: `clr_en` clears every dirty bit from page `clr_first` to `clr_last` inclusive in the next cycle; a write into that range in the same cycle keeps its bit set.
- R12: Synchronous reset clears the dirty bitmap and returns the byte sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gr6 | input | 8 | Graphics register 6; bits 3:2 select the map |
| bank_base | input | VRAM_AW | Base of the relocated 64 KB window |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Write width code |
| req_addr | input | 20 | Host physical byte address |
| req_wdata | input | 32 | Host write data, byte 0 in bits 7:0 |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | 8 | Read data returned to host |
| win_hit | output | 1 | Current byte is inside the window |
| win_miss | output | 1 | Current byte is outside the window |
| mem_en | output | 1 | Memory byte access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | VRAM_AW | Video memory byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory |
| clr_en | input | 1 | Clear a dirty page range |
| clr_first | input | VRAM_AW-PAGE_SHIFT | First page to clear |
| clr_last | input | VRAM_AW-PAGE_SHIFT | Last page to clear |
| dirty | output | 2**(VRAM_AW-PAGE_SHIFT) | Dirty page bitmap |

## Verification
The bench builds the block with an 18-bit video memory (256 KB) and 4 KB pages, giving a 64-bit dirty bitmap that is compared as a whole after every request. With 18 bits, a bank base near the top of memory plus a 64 KB window offset wraps past the end, so the modulo behaviour of the relocated window is reached by random bank values. The small page count also lets random clear ranges cover the first and last page and overlap pages written just before.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    // Aperture limits on the host side (21-bit so address + 3 never wraps)
    localparam logic [20:0] APERTURE_LO = 21'h0A0000;
    localparam logic [20:0] APERTURE_HI = 21'h0BFFFF;
    localparam logic [20:0] BANKED_END  = 21'h0AFFFF;
    localparam logic [20:0] MONO_LO     = 21'h0B0000;
    localparam logic [20:0] MONO_HI     = 21'h0B7FFF;
    localparam logic [20:0] COLOR_LO    = 21'h0B8000;

    typedef enum logic [1:0] {
        MAP_FULL   = 2'd0,
        MAP_BANKED = 2'd1,
        MAP_MONO   = 2'd2,
        MAP_COLOR  = 2'd3
    } map_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_e;

    // Index of the final byte of a request
    function automatic logic [1:0] final_byte(input logic is_write, input xfer_size_e sz);
        if (!is_write)          return 2'd0;
        else if (sz == SZ_BYTE) return 2'd0;
        else if (sz == SZ_HALF) return 2'd1;
        else                    return 2'd3;
    endfunction

endpackage

// File: rtl/lwd_window_map.sv
module lwd_window_map
    import lwd_pkg::*;
#(
    parameter int VRAM_AW = 19
) (
    input  logic [20:0]         byte_addr,
    input  map_sel_e            map_sel,
    input  logic [VRAM_AW-1:0]  bank_base,
    output logic                hit,
    output logic [VRAM_AW-1:0]  offset
);

    logic        in_aperture;
    logic [16:0] rel;
    logic [20:0] rel_full;

    assign in_aperture = (byte_addr >= APERTURE_LO) && (byte_addr <= APERTURE_HI);
    assign rel_full    = byte_addr - APERTURE_LO;
    assign rel         = rel_full[16:0];

    logic unused_rel_hi;
    assign unused_rel_hi = ^rel_full[20:17];

    always_comb begin
        hit    = 1'b0;
        offset = '0;
        unique case (map_sel)
            MAP_FULL: begin
                hit    = in_aperture;
                offset = VRAM_AW'(rel);
            end
            MAP_BANKED: begin
                hit    = in_aperture && (byte_addr <= BANKED_END);
                offset = bank_base + VRAM_AW'(rel[15:0]);
            end
            MAP_MONO: begin
                hit    = (byte_addr >= MONO_LO) && (byte_addr <= MONO_HI);
                offset = VRAM_AW'(rel[14:0]);
            end
            MAP_COLOR: begin
                hit    = (byte_addr >= COLOR_LO) && (byte_addr <= APERTURE_HI);
                offset = VRAM_AW'(rel[14:0]);
            end
            default: begin
                hit    = 1'b0;
                offset = '0;
            end
        endcase
    end

endmodule

// File: rtl/lwd_byte_seq.sv
module lwd_byte_seq
    import lwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  xfer_size_e req_size,
    output logic [1:0] byte_idx,
    output logic       active,
    output logic       ready
);

    seq_state_e st_q;
    logic [1:0] idx_q;
    logic [1:0] last_idx;

    assign last_idx = final_byte(req_write, req_size);
    assign byte_idx = (st_q == SEQ_BURST) ? idx_q : 2'd0;
    assign active   = (st_q == SEQ_BURST) || req_valid;
    assign ready    = active && (byte_idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            idx_q <= 2'd0;
        end else if (active) begin
            if (ready) begin
                st_q  <= SEQ_IDLE;
                idx_q <= 2'd0;
            end else begin
                st_q  <= SEQ_BURST;
                idx_q <= byte_idx + 2'd1;
            end
        end
    end

    AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_IDLE && req_valid && last_idx == 2'd0) |-> ready) // R9
        else $error("single-byte request not ready at once");

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && !ready) |=> (st_q == SEQ_BURST && byte_idx == $past(byte_idx) + 2'd1)) // R8
        else $error("burst did not advance by one byte");

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ready |=> (st_q == SEQ_IDLE)) // R9
        else $error("sequencer not idle after completion");

endmodule

// File: rtl/lwd_dirty_map.sv
module lwd_dirty_map #(
    parameter int PG_W   = 7,
    parameter int NPAGES = 1 << PG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [PG_W-1:0]   set_page,
    input  logic              clr_en,
    input  logic [PG_W-1:0]   clr_first,
    input  logic [PG_W-1:0]   clr_last,
    output logic [NPAGES-1:0] dirty
);

    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_en && (set_page == PG_W'(g));
        assign hit_clr = clr_en && (int'(clr_first) <= g) && (int'(clr_last) >= g);

        always_ff @(posedge clk) begin
            if (rst)          dirty[g] <= 1'b0;
            else if (hit_set) dirty[g] <= 1'b1;
            else if (hit_clr) dirty[g] <= 1'b0;
        end
    end

    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
        set_en |=> dirty[$past(set_page)]) // R10
        else $error("written page not marked");

    AST_CLR_FIRST: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_first <= clr_last && !(set_en && set_page == clr_first))
        |=> !dirty[$past(clr_first)]) // R11
        else $error("first page of clear range still marked");

    AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(dirty)) // R10
        else $error("bitmap changed without write or clear");

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import lwd_pkg::*;
#(
    parameter  int VRAM_AW    = 19,
    parameter  int PAGE_SHIFT = 12,
    localparam int PG_W       = VRAM_AW - PAGE_SHIFT,
    localparam int NPAGES     = 1 << PG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         gr6,
    input  logic [VRAM_AW-1:0] bank_base,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [19:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               req_ready,
    output logic [7:0]         req_rdata,
    output logic               win_hit,
    output logic               win_miss,
    output logic               mem_en,
    output logic               mem_we,
    output logic [VRAM_AW-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               clr_en,
    input  logic [PG_W-1:0]    clr_first,
    input  logic [PG_W-1:0]    clr_last,
    output logic [NPAGES-1:0]  dirty
);

    map_sel_e    map_sel;
    logic [1:0]  byte_idx;
    logic        active;
    logic [20:0] byte_addr;
    logic        dec_hit;
    logic        dirty_set;

    logic unused_gr6;
    assign unused_gr6 = ^{gr6[7:4], gr6[1:0]};

    assign map_sel = map_sel_e'(gr6[3:2]);

    lwd_byte_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (xfer_size_e'(req_size)),
        .byte_idx  (byte_idx),
        .active    (active),
        .ready     (req_ready)
    );

    assign byte_addr = {1'b0, req_addr} + 21'(byte_idx);

    lwd_window_map #(.VRAM_AW(VRAM_AW)) u_map (
        .byte_addr (byte_addr),
        .map_sel   (map_sel),
        .bank_base (bank_base),
        .hit       (dec_hit),
        .offset    (mem_addr)
    );

    assign win_hit   = active && dec_hit;
    assign win_miss  = active && !dec_hit;
    assign mem_en    = win_hit;
    assign mem_we    = req_write;
    assign mem_wdata = req_wdata[8*byte_idx +: 8];
    assign req_rdata = dec_hit ? mem_rdata : 8'hFF;
    assign dirty_set = mem_en && req_write;

    lwd_dirty_map #(.PG_W(PG_W), .NPAGES(NPAGES)) u_dirty (
        .clk       (clk),
        .rst       (rst),
        .set_en    (dirty_set),
        .set_page  (mem_addr[VRAM_AW-1:PAGE_SHIFT]),
        .clr_en    (clr_en),
        .clr_first (clr_first),
        .clr_last  (clr_last),
        .dirty     (dirty)
    );

    AST_TEXT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mem_en && gr6[3]) |-> (mem_addr[VRAM_AW-1:15] == '0)) // R4
        else $error("32 KB window produced an offset beyond its size");

    AST_MISS_NO_MARK: assert property (@(posedge clk) disable iff (rst)
        (win_miss && !clr_en) |=> $stable(dirty)) // R7
        else $error("rejected byte changed the bitmap");

endmodule

// File: tb/legacy_window_decoder_tb.sv
module legacy_window_decoder_tb;

    localparam int AW  = 18;
    localparam int PS  = 12;
    localparam int PGW = AW - PS;
    localparam int NP  = 1 << PGW;

    logic           clk = 1'b0;
    logic           rst;
    logic [7:0]     gr6;
    logic [AW-1:0]  bank_base;
    logic           req_valid, req_write;
    logic [1:0]     req_size;
    logic [19:0]    req_addr;
    logic [31:0]    req_wdata;
    logic           req_ready;
    logic [7:0]     req_rdata;
    logic           win_hit, win_miss, mem_en, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     mem_wdata, mem_rdata;
    logic           clr_en;
    logic [PGW-1:0] clr_first, clr_last;
    logic [NP-1:0]  dirty;

    logic [NP-1:0]  model_dirty;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'h3C;

    legacy_window_decoder #(.VRAM_AW(AW), .PAGE_SHIFT(PS)) u_dut (
        .clk(clk), .rst(rst), .gr6(gr6), .bank_base(bank_base),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .win_hit(win_hit), .win_miss(win_miss),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .clr_en(clr_en),
        .clr_first(clr_first), .clr_last(clr_last), .dirty(dirty)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected window translation from the requirements R1..R5
    function automatic void model_map(input logic [1:0] sel, input int unsigned a,
                                      input logic [AW-1:0] bank,
                                      output bit hit, output logic [AW-1:0] off);
        hit = 0;
        off = '0;
        case (sel)
            2'd0: if (a >= 32'hA0000 && a <= 32'hBFFFF) begin hit = 1; off = AW'(a - 32'hA0000); end
            2'd1: if (a >= 32'hA0000 && a <= 32'hAFFFF) begin hit = 1; off = AW'(bank + AW'(a - 32'hA0000)); end
            2'd2: if (a >= 32'hB0000 && a <= 32'hB7FFF) begin hit = 1; off = AW'(a - 32'hB0000); end
            default: if (a >= 32'hB8000 && a <= 32'hBFFFF) begin hit = 1; off = AW'(a - 32'hB8000); end
        endcase
    endfunction

    task automatic access(input logic [7:0] g6, input logic [AW-1:0] bank, input bit wr,
                          input logic [1:0] sz, input logic [19:0] addr, input logic [31:0] wd);
        int nb;
        nb = !wr ? 1 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4));
        @(negedge clk);
        gr6 = g6; bank_base = bank; req_valid = 1; req_write = wr;
        req_size = sz; req_addr = addr; req_wdata = wd;
        for (int k = 0; k < nb; k++) begin
            bit h;
            logic [AW-1:0] off;
            #2;
            model_map(g6[3:2], int'(addr) + k, bank, h, off);
            check(win_hit == h && win_miss == !h, "R5 window flags", {win_hit, win_miss}, {h, !h});
            check(mem_en == h, h ? "R1 accepted byte strobes" : "R7 rejected byte no strobe", mem_en, h);
            check(req_ready == (k == nb - 1), "R9 ready on last byte", req_ready, (k == nb - 1));
            if (h) begin
                check(mem_addr == off, "R2 R3 R4 mapped address", mem_addr, off);
                check(mem_we == wr, "R8 write flag", mem_we, wr);
            end
            if (wr && h)
                check(mem_wdata == wd[8*k +: 8], "R8 byte order lsb first", mem_wdata, wd[8*k +: 8]);
            if (!wr)
                check(req_rdata == (h ? (off[7:0] ^ 8'h3C) : 8'hFF), "R6 read data",
                      req_rdata, h ? (off[7:0] ^ 8'h3C) : 8'hFF);
            @(posedge clk);
            if (wr && h) model_dirty[off[AW-1:PS]] = 1'b1;
            @(negedge clk);
        end
        req_valid = 0;
        #2;
        check(dirty == model_dirty, "R10 dirty bitmap", dirty, model_dirty);
        check(req_ready == 0 && mem_en == 0, "R9 idle after request", {req_ready, mem_en}, 0);
    endtask

    task automatic clear(input logic [PGW-1:0] f, input logic [PGW-1:0] l);
        @(negedge clk);
        clr_en = 1; clr_first = f; clr_last = l;
        @(posedge clk);
        for (int p = 0; p < NP; p++)
            if (p >= int'(f) && p <= int'(l)) model_dirty[p] = 1'b0;
        @(negedge clk);
        clr_en = 0;
        #2;
        check(dirty == model_dirty, "R11 range clear", dirty, model_dirty);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=hang expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        rst = 1; gr6 = 0; bank_base = 0; req_valid = 0; req_write = 0;
        req_size = 0; req_addr = 0; req_wdata = 0; clr_en = 0;
        clr_first = 0; clr_last = 0; model_dirty = '0;
        seed_val = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        check(dirty == '0, "R12 reset bitmap", dirty, 0);
        check(req_ready == 0 && mem_en == 0, "R12 reset idle", {req_ready, mem_en}, 0);

        // Directed corners
        access(8'h00, '0, 1, 2'd2, 20'hBFFFE, 32'hA1B2C3D4);     // R1 R5 word past top
        access(8'h04, 18'h3F000, 1, 2'd2, 20'hAFFFE, 32'h11223344); // R2 crossing + wrap
        access(8'h04, 18'h20000, 0, 2'd0, 20'hB0000, 32'h0);     // R2 rejected read
        access(8'h08, '0, 1, 2'd1, 20'hB7FFF, 32'h0000BEEF);     // R3 edge
        access(8'h08, '0, 0, 2'd0, 20'hB8000, 32'h0);            // R3 reject
        access(8'h0C, '0, 1, 2'd3, 20'hB8000, 32'hCAFEF00D);     // R4 R8 size 3
        access(8'h0C, '0, 1, 2'd0, 20'hB7FFF, 32'h5A);           // R4 reject
        access(8'hF3, '0, 1, 2'd2, 20'h9FFFE, 32'h01020304);     // R1 R5 below base, other gr6 bits
        access(8'h0C, '0, 0, 2'd0, 20'hBFFFF, 32'h0);            // R6 read hit
        clear(6'd0, 6'd63);
        access(8'h00, '0, 1, 2'd2, 20'hA0FFE, 32'hDEADBEEF);     // R10 two pages
        clear(6'd1, 6'd0);                                        // R11 empty range
        clear(6'd1, 6'd1);

        // R11 same-cycle write wins over clear
        @(negedge clk);
        gr6 = 8'h00; req_valid = 1; req_write = 1; req_size = 2'd0;
        req_addr = 20'hA2000; req_wdata = 32'h77;
        clr_en = 1; clr_first = 6'd0; clr_last = 6'd10;
        @(posedge clk);
        for (int p = 0; p <= 10; p++) model_dirty[p] = 1'b0;
        model_dirty[2] = 1'b1;
        @(negedge clk);
        req_valid = 0; clr_en = 0;
        #2;
        check(dirty == model_dirty, "R11 write beats clear", dirty, model_dirty);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  g;
            logic [19:0] a;
            g = 8'($urandom);
            a = 20'(32'h9FFF0 + ($urandom % 32'h20030));
            access(g, AW'($urandom), 1'($urandom), 2'($urandom), a, $urandom);
            if (i % 37 == 36) begin
                logic [PGW-1:0] f;
                f = PGW'($urandom);
                clear(f, PGW'(int'(f) + int'($urandom % 8)));
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule